// File: doc/BRIEF.md
# Accelerator Mapping CSR File

This block is the host-side register file that a hart uses to claim remote accelerators and to steer its four custom instruction opcodes toward them. It has three kinds of register. Sixteen slot registers each hold a physical manager ID and an ownership bit. Four route registers each pick one slot for one custom opcode. A fence register names the slot that the next memory fence targets. Software reaches all of them through a plain CSR read/write port. The dispatch logic of the core asks the lookup port which manager a given custom opcode should go to, and whether that path can be used at all.

The ownership bit reads differently from how it writes. Writing a 1 asks for ownership: the block emits a one-cycle acquire request toward the messaging layer. The bit reads back as 1 only after a success result for that slot comes back on the response pins. Writing a 0 to an owned slot gives ownership up: the block emits a one-cycle release request and the bit clears. The messaging layer itself is outside this block. The request and response pins are plain control strobes with no back-pressure. The requester must accept a pulse in the cycle it appears, and the block takes a response in any cycle its valid is high.

Top module: `accel_map_csr`

## Requirements
- R1: After reset, every register reads 0, `lk_valid` is 0, `fence_slot` is 0, and neither `acq_req` nor `rel_req` is high.
- R2: Route registers sit at addresses 0x800 to 0x803, one per custom opcode 0 to 3. Bits 3:0 are stored and read back, and all higher read bits are 0.
- R3: The fence register at 0x804 stores bits 3:0, reads them back, and drives them on `fence_slot`.
- R4: Slot register n sits at 0x810+n. Bits 7:0 hold the manager ID. Read bit 8 is the owned state, and all other read bits are 0.
- R5: A write to a slot register with bit 8 set raises `acq_req` for exactly the next cycle, with that slot on `req_slot` and the written ID on `req_mgr`. The slot's owned bit becomes 0 and the slot waits for a result.
- R6: A response (`rsp_valid`) with `rsp_ok`=1 for a waiting slot sets its owned bit. A response with `rsp_ok`=0 leaves the bit 0. A response for a slot that is not waiting changes nothing.
- R7: A write with bit 8 clear to an owned slot raises `rel_req` for exactly the next cycle and clears ownership. The same write to a slot that is not owned raises no pulse.
- R8: `lk_mgr` is the manager ID of the slot that the route register for `lk_opc` selects. `lk_valid` is 1 only when that slot is owned. Both are combinational.
- R9: A read or write to an address from 0x805 to 0x80F raises `csr_illegal` in the same cycle, reads 0, and changes no register. Addresses outside 0x800 to 0x81F read 0 and change no register.
- R10: When a slot write and a response for the same slot arrive in the same cycle, the write decides the slot's state and the response is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | CSR write strobe |
| csr_re | input | 1 | CSR read strobe |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data (combinational) |
| csr_illegal | output | 1 | Access hit the unimplemented hole |
| lk_opc | input | 2 | Custom opcode number to route |
| lk_mgr | output | 8 | Manager ID for that opcode |
| lk_valid | output | 1 | The routed slot is owned |
| fence_slot | output | 4 | Slot named for the next fence |
| acq_req | output | 1 | One-cycle acquire request |
| rel_req | output | 1 | One-cycle release request |
| req_slot | output | 4 | Slot of the current request |
| req_mgr | output | 8 | Manager ID of the current request |
| rsp_valid | input | 1 | Acquire result strobe |
| rsp_slot | input | 4 | Slot the result belongs to |
| rsp_ok | input | 1 | Acquire succeeded |

## Verification
The bench goes after the gap between writing the ownership bit and reading it. A design that echoed the written bit would read 1 before any result and after a failure. Stray responses are also targeted: a response for a slot that is not waiting, or a second response after a failure, would grant ownership in a design that does not track the waiting state. A slot write that meets a response in the same cycle shows whether the write wins. A wrong priority leaves the slot owned with no release pulse. The unimplemented hole, release on slots that are not owned, and lookups through a slot that failed to acquire cover illegal flags that do not fire, spurious release pulses, and routing to a manager that was never granted.

// File: rtl/accel_map_pkg.sv
package accel_map_pkg;
  localparam int CSR_AW  = 12;
  localparam int MGR_W   = 8;
  localparam int IDX_W   = 4;
  localparam int NUM_OPC = 4;
  localparam int OPC_W   = $clog2(NUM_OPC);
  localparam int OWN_BIT = MGR_W;

  localparam logic [CSR_AW-1:0] ROUTE_BASE = 12'h800;
  localparam logic [CSR_AW-1:0] FENCE_ADDR = 12'h804;
  localparam logic [CSR_AW-1:0] HOLE_LO    = 12'h805;
  localparam logic [CSR_AW-1:0] HOLE_HI    = 12'h80F;
  localparam logic [CSR_AW-5:0] SLOT_PAGE  = 8'h81;

  typedef struct packed {
    logic route;
    logic fence;
    logic slot;
    logic hole;
  } csr_sel_t;
endpackage

// File: rtl/accel_map_decode.sv
module accel_map_decode
  import accel_map_pkg::*;
#(
  parameter int NUM_SLOTS = 16
) (
  input  logic [CSR_AW-1:0] addr,
  output csr_sel_t          sel,
  output logic [IDX_W-1:0]  idx
);
  logic page_hit;
  logic idx_ok;

  always_comb begin
    idx       = addr[IDX_W-1:0];
    page_hit  = (addr[CSR_AW-1:IDX_W] == SLOT_PAGE);
    idx_ok    = ({1'b0, idx} < (IDX_W+1)'(NUM_SLOTS));
    sel.route = (addr >= ROUTE_BASE) && (addr < ROUTE_BASE + CSR_AW'(NUM_OPC));
    sel.fence = (addr == FENCE_ADDR);
    sel.slot  = page_hit && idx_ok;
    sel.hole  = ((addr >= HOLE_LO) && (addr <= HOLE_HI)) || (page_hit && !idx_ok);
  end
endmodule

// File: rtl/accel_map_slots.sv
module accel_map_slots
  import accel_map_pkg::*;
#(
  parameter int NUM_SLOTS = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [MGR_W-1:0]                 wr_mgr,
  input  logic                             wr_own,
  input  logic                             rsp_valid,
  input  logic [IDX_W-1:0]                 rsp_slot,
  input  logic                             rsp_ok,
  output logic [NUM_SLOTS-1:0][MGR_W-1:0]  mgr_q,
  output logic [NUM_SLOTS-1:0]             own_q,
  output logic                             acq_req,
  output logic                             rel_req,
  output logic [IDX_W-1:0]                 req_slot,
  output logic [MGR_W-1:0]                 req_mgr
);
  logic [NUM_SLOTS-1:0] wait_q;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic hit_wr, hit_rsp;
    assign hit_wr  = wr_en && (wr_idx == IDX_W'(s));
    assign hit_rsp = rsp_valid && (rsp_slot == IDX_W'(s)) && wait_q[s];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mgr_q[s]  <= '0;
        own_q[s]  <= 1'b0;
        wait_q[s] <= 1'b0;
      end else if (hit_wr) begin
        mgr_q[s]  <= wr_mgr;
        own_q[s]  <= 1'b0;
        wait_q[s] <= wr_own;
      end else if (hit_rsp) begin
        own_q[s]  <= rsp_ok;
        wait_q[s] <= 1'b0;
      end
    end

    // R6: ownership appears only through a successful result for this slot
    assert_own_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(own_q[s]) |-> $past(rsp_valid && rsp_ok && rsp_slot == IDX_W'(s)));
    // R10: a slot write in the previous cycle always leaves the slot unowned
    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en && wr_idx == IDX_W'(s)) |-> !own_q[s]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acq_req  <= 1'b0;
      rel_req  <= 1'b0;
      req_slot <= '0;
      req_mgr  <= '0;
    end else begin
      acq_req <= wr_en && wr_own;
      rel_req <= wr_en && !wr_own && own_q[wr_idx];
      if (wr_en) begin
        req_slot <= wr_idx;
        req_mgr  <= wr_mgr;
      end
    end
  end

  // R5: an acquire pulse follows a slot write with the ownership bit set
  assert_acq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acq_req |-> $past(wr_en && wr_own));
  // R7: a release pulse follows a slot write with the ownership bit clear
  assert_rel_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rel_req |-> $past(wr_en && !wr_own));
  assert_req_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(acq_req && rel_req));
endmodule

// File: rtl/accel_map_route.sv
module accel_map_route
  import accel_map_pkg::*;
#(
  parameter int NUM_SLOTS = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_route,
  input  logic                             wr_fence,
  input  logic [OPC_W-1:0]                 wr_opc,
  input  logic [IDX_W-1:0]                 wr_val,
  input  logic [NUM_SLOTS-1:0][MGR_W-1:0]  mgr_q,
  input  logic [NUM_SLOTS-1:0]             own_q,
  input  logic [OPC_W-1:0]                 lk_opc,
  output logic [NUM_OPC-1:0][IDX_W-1:0]    route_q,
  output logic [IDX_W-1:0]                 fence_q,
  output logic [MGR_W-1:0]                 lk_mgr,
  output logic                             lk_valid
);
  logic [IDX_W-1:0] pick;

  for (genvar o = 0; o < NUM_OPC; o++) begin : g_route
    always_ff @(posedge clk) begin
      if (!rst_n)                                    route_q[o] <= '0;
      else if (wr_route && wr_opc == OPC_W'(o))      route_q[o] <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        fence_q <= '0;
    else if (wr_fence) fence_q <= wr_val;
  end

  always_comb begin
    pick     = route_q[lk_opc];
    lk_mgr   = '0;
    lk_valid = 1'b0;
    if ({1'b0, pick} < (IDX_W+1)'(NUM_SLOTS)) begin
      lk_mgr   = mgr_q[pick];
      lk_valid = own_q[pick];
    end
  end

  // R2: route table changes only on a route write
  assert_route_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_route |=> $stable(route_q));
  // R3: fence register changes only on a fence write
  assert_fence_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fence |=> $stable(fence_q));
  // R8: a usable route needs at least one owned slot
  assert_lookup_owned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (own_q != '0));
endmodule

// File: rtl/accel_map_csr.sv
module accel_map_csr
  import accel_map_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int XLEN      = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic              csr_re,
  input  logic [11:0]       csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              csr_illegal,
  input  logic [1:0]        lk_opc,
  output logic [7:0]        lk_mgr,
  output logic              lk_valid,
  output logic [3:0]        fence_slot,
  output logic              acq_req,
  output logic              rel_req,
  output logic [3:0]        req_slot,
  output logic [7:0]        req_mgr,
  input  logic              rsp_valid,
  input  logic [3:0]        rsp_slot,
  input  logic              rsp_ok
);
  csr_sel_t                        sel;
  logic [IDX_W-1:0]                idx;
  logic [NUM_SLOTS-1:0][MGR_W-1:0] mgr_q;
  logic [NUM_SLOTS-1:0]            own_q;
  logic [NUM_OPC-1:0][IDX_W-1:0]   route_q;

  accel_map_decode #(.NUM_SLOTS(NUM_SLOTS)) u_dec (
    .addr (csr_addr),
    .sel  (sel),
    .idx  (idx)
  );

  accel_map_slots #(.NUM_SLOTS(NUM_SLOTS)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (csr_we && sel.slot),
    .wr_idx    (idx),
    .wr_mgr    (csr_wdata[MGR_W-1:0]),
    .wr_own    (csr_wdata[OWN_BIT]),
    .rsp_valid (rsp_valid),
    .rsp_slot  (rsp_slot),
    .rsp_ok    (rsp_ok),
    .mgr_q     (mgr_q),
    .own_q     (own_q),
    .acq_req   (acq_req),
    .rel_req   (rel_req),
    .req_slot  (req_slot),
    .req_mgr   (req_mgr)
  );

  accel_map_route #(.NUM_SLOTS(NUM_SLOTS)) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_route (csr_we && sel.route),
    .wr_fence (csr_we && sel.fence),
    .wr_opc   (idx[OPC_W-1:0]),
    .wr_val   (csr_wdata[IDX_W-1:0]),
    .mgr_q    (mgr_q),
    .own_q    (own_q),
    .lk_opc   (lk_opc),
    .route_q  (route_q),
    .fence_q  (fence_slot),
    .lk_mgr   (lk_mgr),
    .lk_valid (lk_valid)
  );

  always_comb begin
    csr_rdata = '0;
    if (sel.route)      csr_rdata[IDX_W-1:0] = route_q[idx[OPC_W-1:0]];
    else if (sel.fence) csr_rdata[IDX_W-1:0] = fence_slot;
    else if (sel.slot)  csr_rdata[OWN_BIT:0] = {own_q[idx], mgr_q[idx]};
  end

  assign csr_illegal = (csr_we || csr_re) && sel.hole;

  // R9: the hole never overlaps a real register
  assert_hole_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel.route, sel.fence, sel.slot, sel.hole}));
  // R9: an illegal access reads zero
  assert_hole_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> (csr_rdata == '0));
endmodule

// File: tb/sim_accel_map_csr.sv
module sim_accel_map_csr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0, csr_re = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        csr_illegal;
  logic [1:0]  lk_opc = '0;
  logic [7:0]  lk_mgr;
  logic        lk_valid;
  logic [3:0]  fence_slot;
  logic        acq_req, rel_req;
  logic [3:0]  req_slot;
  logic [7:0]  req_mgr;
  logic        rsp_valid = 1'b0;
  logic [3:0]  rsp_slot = '0;
  logic        rsp_ok = 1'b0;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  accel_map_csr u0 (.*);

  // addr, write data, expected read-back
  localparam logic [43:0] VEC [7] = '{
    {12'h800, 16'hFFF5, 16'h0005},
    {12'h803, 16'h000A, 16'h000A},
    {12'h804, 16'h0007, 16'h0007},
    {12'h812, 16'h00AB, 16'h00AB},
    {12'h81F, 16'hFE3C, 16'h003C},
    {12'h808, 16'h1234, 16'h0000},
    {12'h820, 16'h0055, 16'h0000}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0; csr_wdata = '0;
  endtask

  task automatic do_read(input logic [11:0] a, output logic [63:0] d, output logic ill);
    @(negedge clk);
    csr_re = 1'b1; csr_addr = a;
    #1;
    d = csr_rdata; ill = csr_illegal;
    csr_re = 1'b0;
  endtask

  task automatic respond(input logic [3:0] s, input logic ok);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_slot = s; rsp_ok = ok;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [63:0] rd;
    logic        ill;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    do_read(12'h813, rd, ill); check("R1 slot read", rd, 0);
    do_read(12'h800, rd, ill); check("R1 route read", rd, 0);
    check("R1 fence", fence_slot, 0);
    #1 check("R1 lk_valid", lk_valid, 0);
    check("R1 pulses", {acq_req, rel_req}, 0);

    // R2 R3 R4 R9: table of write/read-back vectors
    for (int i = 0; i < 7; i++) begin
      do_write(VEC[i][43:32], 64'(VEC[i][31:16]));
      do_read(VEC[i][43:32], rd, ill);
      check("R2/R3/R4/R9 vector", rd, 64'(VEC[i][15:0]));
    end
    check("R3 fence_slot", fence_slot, 4'h7);
    check("R7 no release on unowned", rel_req, 0);

    // R5: acquire request pulse
    do_write(12'h813, 64'h142);
    check("R5 acq_req", acq_req, 1);
    check("R5 req_slot", req_slot, 4'd3);
    check("R5 req_mgr", req_mgr, 8'h42);
    @(negedge clk); check("R5 single pulse", acq_req, 0);
    do_read(12'h813, rd, ill); check("R5 owned stays 0 before result", rd, 64'h042);

    // R6: success
    respond(4'd3, 1'b1);
    do_read(12'h813, rd, ill); check("R6 owned after success", rd, 64'h142);

    // R8: lookup through route
    do_write(12'h801, 64'h3);
    lk_opc = 2'd1; #1;
    check("R8 lk_valid owned", lk_valid, 1);
    check("R8 lk_mgr", lk_mgr, 8'h42);

    // R6: failure and stray responses
    do_write(12'h815, 64'h199);
    respond(4'd5, 1'b0);
    do_read(12'h815, rd, ill); check("R6 failure keeps 0", rd, 64'h099);
    respond(4'd5, 1'b1);
    do_read(12'h815, rd, ill); check("R6 late response ignored", rd, 64'h099);
    respond(4'd6, 1'b1);
    do_read(12'h816, rd, ill); check("R6 non-waiting slot ignored", rd, 0);
    lk_opc = 2'd0; #1;  // route 0 -> slot 5
    check("R8 lk_valid unowned", lk_valid, 0);
    check("R8 lk_mgr unowned", lk_mgr, 8'h99);

    // R7: release
    do_write(12'h813, 64'h042);
    check("R7 rel_req", rel_req, 1);
    check("R7 req_slot", req_slot, 4'd3);
    @(negedge clk); check("R7 single pulse", rel_req, 0);
    do_read(12'h813, rd, ill); check("R7 cleared", rd, 64'h042);
    lk_opc = 2'd1; #1; check("R8 lk_valid after release", lk_valid, 0);

    // R10: write and response collide
    do_write(12'h817, 64'h177);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = 12'h817; csr_wdata = 64'h077;
    rsp_valid = 1'b1; rsp_slot = 4'd7; rsp_ok = 1'b1;
    @(negedge clk);
    csr_we = 1'b0; rsp_valid = 1'b0;
    check("R10 no pulse", {acq_req, rel_req}, 0);
    do_read(12'h817, rd, ill); check("R10 write wins", rd, 64'h077);
    respond(4'd7, 1'b1);
    do_read(12'h817, rd, ill); check("R10 response dropped", rd, 64'h077);

    // R9: illegal flag and no side effect
    do_read(12'h805, rd, ill); check("R9 illegal read flag", ill, 1);
    do_read(12'h804, rd, ill); check("R9 legal no flag", ill, 0);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = 12'h80F; csr_wdata = 64'h1;
    #1 check("R9 illegal write flag", csr_illegal, 1);
    @(negedge clk); csr_we = 1'b0;
    check("R9 fence untouched", fence_slot, 4'h7);
    do_read(12'h800, rd, ill); check("R9 route untouched", rd, 64'h5);

    finish_run();
  end
endmodule